// File: doc/BRIEF.md
# Pipelined Horizon Channel Scheduler

This block hands out output channels to burst reservations using horizon scheduling. Each channel has a horizon, the time up to which it is already booked. A request brings a start time and an end time. The block grants the channel whose horizon is the latest one still strictly before the start time. That channel's horizon then becomes the request's end time. If every horizon is at or beyond the start time, the request is reported as unscheduled.

The horizons are kept in a list of (horizon, channel) pairs in ascending order of horizon. A request walks down a chain of stages, one stage per list entry plus one final stage. On its way it finds its channel, pulls that entry out, and puts the updated entry back in sorted position. Each stage only looks at its own list slot, so a new request can be taken every two cycles whatever the channel count. A result comes out a fixed number of cycles later, in the order the requests were accepted. The caller must supply an end time later than the start time.

Top module: `hws_sched`

## Requirements
- R1: After synchronous reset every horizon is zero and list slot k holds channel k. The request input is ready and no result is flagged. A first request with start time 1 therefore gets channel CH-1.
- R2: A request whose start time a exceeds at least one horizon is granted the channel with the largest horizon below a. Among equal horizons it takes the entry placed last in the list.
- R3: A request with no horizon strictly below its start time returns the unscheduled flag with the channel field at zero, and the list is left unchanged.
- R4: The granted channel is put back with the request's end time as its horizon. It goes ahead of the first remaining entry whose horizon is greater than or equal to that end time, so the list stays in ascending order.
- R5: A request is taken on a clock edge where valid and ready are both high. Ready is low in the cycle after such an edge, so requests are at least two cycles apart. A request held while ready is low is not taken.
- R6: The result strobe is a single-cycle pulse. It rises in the cycle that follows the (CH+1)-th rising edge after the accepting edge.
- R7: Every request sees the list as left by all requests accepted before it, even when requests arrive back to back. Results leave in acceptance order, one per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | A request is offered |
| reqReady | output | 1 | The block can take a request at this edge |
| reqStart | input | TW | Burst start time |
| reqEnd | input | TW | Burst end time, greater than reqStart |
| resValid | output | 1 | One-cycle result strobe |
| resChannel | output | CW | Granted channel, zero when unscheduled |
| resMiss | output | 1 | Request could not be scheduled |

## Verification
A short directed run starts from the reset list. It tells an early-start miss apart from a grant among all-equal horizons. It then checks that an end time equal to an existing horizon is inserted ahead of it, which a later grant among equal horizons exposes. A long stream of pseudo-random start and end pairs, issued back to back and with random idle gaps, mixes misses, grants and re-insertions at every list position. This separates correct stage-to-stage forwarding from a design that reads stale list slots. A final sweep of start times from 0 to 63 walks the selection boundary across each horizon value. Every result is compared against a sorted-list model and timed against the fixed latency.

// File: rtl/hws_pkg.sv
package hws_pkg;

  // Where a request stands on its walk down the stages.
  typedef enum logic [2:0] {
    MD_NEW,     // not yet compared with slot 0
    MD_SEARCH,  // every slot so far is below the start time
    MD_SHIFT,   // channel picked, later entries move up one slot
    MD_DONE,    // updated entry written back
    MD_MISS     // nothing below the start time
  } mode_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;
  } ctrl_s;

endpackage

// File: rtl/hws_ctrl.sv
module hws_ctrl
  import hws_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  reqValid,
  output logic  reqReady,
  output ctrl_s ctrl
);

  logic coolDown;

  assign reqReady  = !coolDown;
  assign ctrl.load = reqValid && reqReady;

  // One idle cycle after each accepted request keeps requests two stages apart.
  always_ff @(posedge clk) begin
    if (rst) coolDown <= 1'b0;
    else     coolDown <= ctrl.load;
  end

endmodule

// File: rtl/hws_stage.sv
module hws_stage
  import hws_pkg::*;
#(
  parameter int TW = 16,
  parameter int CW = 3
) (
  input  logic          inValid,
  input  mode_e         inMode,
  input  logic [TW-1:0] inStart,
  input  logic [TW-1:0] inEnd,
  input  logic [TW-1:0] inPrevH,
  input  logic [CW-1:0] inPrevC,
  input  logic [CW-1:0] inChan,
  input  logic [TW-1:0] curH,
  input  logic [CW-1:0] curC,
  input  logic          curInf,
  output logic          outValid,
  output mode_e         outMode,
  output logic [TW-1:0] outStart,
  output logic [TW-1:0] outEnd,
  output logic [TW-1:0] outPrevH,
  output logic [CW-1:0] outPrevC,
  output logic [CW-1:0] outChan,
  output logic          wrEn,
  output logic [TW-1:0] wrH,
  output logic [CW-1:0] wrC
);

  logic curBelow;  // slot horizon strictly before the start time
  logic curAtEnd;  // slot horizon at or after the end time

  assign curBelow = !curInf && (curH < inStart);
  assign curAtEnd = curInf || (curH >= inEnd);

  always_comb begin
    outValid = inValid;
    outMode  = inMode;
    outStart = inStart;
    outEnd   = inEnd;
    outPrevH = inPrevH;
    outPrevC = inPrevC;
    outChan  = inChan;
    wrEn     = 1'b0;
    wrH      = curH;
    wrC      = curC;
    unique case (inMode)
      MD_NEW: begin
        outChan = '0;
        if (curBelow) begin
          outMode  = MD_SEARCH;
          outPrevH = curH;
          outPrevC = curC;
        end else begin
          outMode = MD_MISS;
        end
      end
      MD_SEARCH: begin
        if (curBelow) begin
          // previous candidate is superseded: it stays in its slot
          wrEn     = 1'b1;
          wrH      = inPrevH;
          wrC      = inPrevC;
          outPrevH = curH;
          outPrevC = curC;
        end else begin
          outChan = inPrevC;
          wrEn    = 1'b1;
          if (curAtEnd) begin
            wrH     = inEnd;
            wrC     = inPrevC;
            outMode = MD_DONE;
          end else begin
            outMode = MD_SHIFT;
          end
        end
      end
      MD_SHIFT: begin
        wrEn = 1'b1;
        if (curAtEnd) begin
          wrH     = inEnd;
          wrC     = inChan;
          outMode = MD_DONE;
        end
      end
      default: ;
    endcase
    wrEn = wrEn && inValid;
  end

endmodule

// File: rtl/hws_datapath.sv
module hws_datapath
  import hws_pkg::*;
#(
  parameter  int CH = 8,
  parameter  int TW = 16,
  localparam int CW = (CH > 1) ? $clog2(CH) : 1,
  localparam int NS = CH + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  ctrl_s         ctrl,
  input  logic [TW-1:0] reqStart,
  input  logic [TW-1:0] reqEnd,
  output logic          resValid,
  output logic [CW-1:0] resChannel,
  output logic          resMiss
);

  // Sorted status list.
  logic [TW-1:0] listH [CH];
  logic [CW-1:0] listC [CH];

  // Request registers in front of each stage.
  logic          pV     [NS];
  mode_e         pMode  [NS];
  logic [TW-1:0] pStart [NS];
  logic [TW-1:0] pEnd   [NS];
  logic [TW-1:0] pPrevH [NS];
  logic [CW-1:0] pPrevC [NS];
  logic [CW-1:0] pChan  [NS];

  // Stage outputs.
  logic          oV     [NS];
  mode_e         oMode  [NS];
  logic [TW-1:0] oStart [NS];
  logic [TW-1:0] oEnd   [NS];
  logic [TW-1:0] oPrevH [NS];
  logic [CW-1:0] oPrevC [NS];
  logic [CW-1:0] oChan  [NS];
  logic          wEn    [NS];
  logic [TW-1:0] wH     [NS];
  logic [CW-1:0] wC     [NS];

  logic [TW-1:0] curH   [NS];
  logic [CW-1:0] curC   [NS];
  logic          curInf [NS];

  for (genvar i = 0; i < NS; i++) begin : g_stage
    if (i < CH) begin : g_slot
      assign curH[i]   = listH[i];
      assign curC[i]   = listC[i];
      assign curInf[i] = 1'b0;
    end else begin : g_tail
      assign curH[i]   = '0;
      assign curC[i]   = '0;
      assign curInf[i] = 1'b1;
    end

    hws_stage #(.TW(TW), .CW(CW)) stage_i (
      .inValid (pV[i]),     .inMode  (pMode[i]),  .inStart (pStart[i]),
      .inEnd   (pEnd[i]),   .inPrevH (pPrevH[i]), .inPrevC (pPrevC[i]),
      .inChan  (pChan[i]),  .curH    (curH[i]),   .curC    (curC[i]),
      .curInf  (curInf[i]), .outValid(oV[i]),     .outMode (oMode[i]),
      .outStart(oStart[i]), .outEnd  (oEnd[i]),   .outPrevH(oPrevH[i]),
      .outPrevC(oPrevC[i]), .outChan (oChan[i]),  .wrEn    (wEn[i]),
      .wrH     (wH[i]),     .wrC     (wC[i])
    );
  end

  // Stage j+1 owns the write port of slot j, one slot behind its read.
  for (genvar j = 0; j < CH; j++) begin : g_list
    always_ff @(posedge clk) begin
      if (rst) begin
        listH[j] <= '0;
        listC[j] <= CW'(j);
      end else if (wEn[j+1]) begin
        listH[j] <= wH[j+1];
        listC[j] <= wC[j+1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NS; k++) pV[k] <= 1'b0;
      resValid   <= 1'b0;
      resMiss    <= 1'b0;
      resChannel <= '0;
    end else begin
      pV[0]     <= ctrl.load;
      pMode[0]  <= MD_NEW;
      pStart[0] <= reqStart;
      pEnd[0]   <= reqEnd;
      pPrevH[0] <= '0;
      pPrevC[0] <= '0;
      pChan[0]  <= '0;
      for (int k = 1; k < NS; k++) begin
        pV[k]     <= oV[k-1];
        pMode[k]  <= oMode[k-1];
        pStart[k] <= oStart[k-1];
        pEnd[k]   <= oEnd[k-1];
        pPrevH[k] <= oPrevH[k-1];
        pPrevC[k] <= oPrevC[k-1];
        pChan[k]  <= oChan[k-1];
      end
      resValid   <= oV[CH];
      resMiss    <= (oMode[CH] == MD_MISS);
      resChannel <= oChan[CH];
    end
  end

endmodule

// File: rtl/hws_sched.sv
module hws_sched
  import hws_pkg::*;
#(
  parameter  int CH = 8,
  parameter  int TW = 16,
  localparam int CW = (CH > 1) ? $clog2(CH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reqValid,
  output logic          reqReady,
  input  logic [TW-1:0] reqStart,
  input  logic [TW-1:0] reqEnd,
  output logic          resValid,
  output logic [CW-1:0] resChannel,
  output logic          resMiss
);

  ctrl_s ctrl;

  hws_ctrl ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .reqValid(reqValid),
    .reqReady(reqReady),
    .ctrl    (ctrl)
  );

  hws_datapath #(.CH(CH), .TW(TW)) dp_i (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .reqStart  (reqStart),
    .reqEnd    (reqEnd),
    .resValid  (resValid),
    .resChannel(resChannel),
    .resMiss   (resMiss)
  );

endmodule

// File: rtl/hws_sched_chk.sv
module hws_sched_chk #(
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          reqValid,
  input logic          reqReady,
  input logic          resValid,
  input logic [CW-1:0] resChannel,
  input logic          resMiss
);

  logic [15:0] pending;
  logic        accept;

  assign accept = reqValid && reqReady;

  always_ff @(posedge clk) begin
    if (rst) pending <= '0;
    else     pending <= pending + 16'(accept) - 16'(resValid);
  end

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (reqReady && !resValid));

  p_ready_gap_r5: assert property (@(posedge clk) disable iff (rst)
    accept |=> !reqReady);

  p_miss_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (resValid && resMiss) |-> (resChannel == '0));

  p_res_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    resValid |=> !resValid);

  p_no_orphan_r7: assert property (@(posedge clk) disable iff (rst)
    resValid |-> (pending != '0));

endmodule

bind hws_sched hws_sched_chk #(.CW(CW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .resValid  (resValid),
  .resChannel(resChannel),
  .resMiss   (resMiss)
);

// File: tb/hws_sched_tb_top.sv
module hws_sched_tb_top;

  localparam int NCH = 4;
  localparam int TWB = 8;
  localparam int CWB = 2;
  localparam int LAT = NCH + 2;  // negedge count from accept-cycle negedge to result

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           reqValid = 1'b0;
  logic           reqReady;
  logic [TWB-1:0] reqStart = '0;
  logic [TWB-1:0] reqEnd = '0;
  logic           resValid;
  logic [CWB-1:0] resChannel;
  logic           resMiss;

  int checks = 0;
  int fails = 0;
  int edges = 0;
  bit lastAccepted = 1'b0;
  bit acceptedNow;
  int lcg = 12345;

  int mH [NCH];
  int mC [NCH];
  int qChan [$];
  bit qMiss [$];
  int qDue [$];

  always #5 clk = ~clk;
  always @(posedge clk) edges++;

  hws_sched #(.CH(NCH), .TW(TWB)) dut_i (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqStart(reqStart), .reqEnd(reqEnd), .resValid(resValid),
    .resChannel(resChannel), .resMiss(resMiss)
  );

  function automatic int nextRand();
    lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
    return lcg >>> 8;
  endfunction

  // Sorted-list reference: last entry below start, reinsert ahead of first >= end.
  function automatic void modelReq(input int a, input int e, output bit miss, output int ch);
    int s = -1;
    int q;
    for (int i = 0; i < NCH; i++) if (mH[i] < a) s = i;
    if (s < 0) begin
      miss = 1'b1; ch = 0;
      return;
    end
    miss = 1'b0; ch = mC[s];
    for (int i = s; i < NCH - 1; i++) begin
      mH[i] = mH[i+1]; mC[i] = mC[i+1];
    end
    q = NCH - 1;
    for (int i = NCH - 2; i >= 0; i--) if (mH[i] >= e) q = i;
    for (int i = NCH - 1; i > q; i--) begin
      mH[i] = mH[i-1]; mC[i] = mC[i-1];
    end
    mH[q] = e; mC[q] = ch;
  endfunction

  task automatic checkOut();
    if (resValid) begin
      checks++;
      if (qDue.size() == 0) begin
        fails++;
        $display("FAIL R7 unexpected result: got channel %0d miss %0d, expected none",
                 resChannel, resMiss);
      end else begin
        int  ec = qChan.pop_front();
        bit  em = qMiss.pop_front();
        int  ed = qDue.pop_front();
        if (ed != edges) begin
          fails++;
          $display("FAIL R6 latency: got edge %0d expected edge %0d", edges, ed);
        end else if (resMiss != em) begin
          fails++;
          $display("FAIL R3 miss flag: got %0d expected %0d", resMiss, em);
        end else if (int'(resChannel) != ec) begin
          fails++;
          $display("FAIL R2 channel: got %0d expected %0d", resChannel, ec);
        end
      end
    end else if (qDue.size() != 0 && qDue[0] == edges) begin
      checks++; fails++;
      $display("FAIL R6 result missing at edge %0d: got none expected channel %0d",
               edges, qChan[0]);
      void'(qChan.pop_front()); void'(qMiss.pop_front()); void'(qDue.pop_front());
    end
  endtask

  task automatic cycle(input bit v, input int a, input int e);
    @(negedge clk);
    checkOut();
    if (lastAccepted) begin  // R5: ready drops after an accepting edge
      checks++;
      if (reqReady !== 1'b0) begin
        fails++;
        $display("FAIL R5 ready after accept: got %0d expected 0", reqReady);
      end
    end
    reqValid = v;
    reqStart = TWB'(a);
    reqEnd   = TWB'(e);
    acceptedNow = v && reqReady;
    if (acceptedNow) begin
      bit m; int c;
      modelReq(a, e, m, c);
      qChan.push_back(c); qMiss.push_back(m); qDue.push_back(edges + LAT);
    end
    lastAccepted = acceptedNow;
  endtask

  task automatic send(input int a, input int e);
    do cycle(1'b1, a, e); while (!acceptedNow);
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) begin mH[i] = 0; mC[i] = i; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state at the ports
    checks++;
    if (reqReady !== 1'b1 || resValid !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset state: got ready %0d valid %0d expected 1 0", reqReady, resValid);
    end
    // Directed: R3 miss at start 0, R1/R2 grant last of equal horizons,
    // R4 end time equal to a horizon goes ahead of it, R7 back to back.
    send(0, 5);
    send(1, 10);
    send(10, 20);
    send(5, 10);
    send(11, 30);
    send(30, 31);
    send(2, 3);
    repeat (LAT + 2) cycle(1'b0, 0, 0);
    // Back-to-back pseudo-random stream (R2, R4, R7)
    for (int n = 0; n < 300; n++) begin
      int a = nextRand() % 200;
      send(a, a + 1 + nextRand() % 50);
    end
    // Same with idle gaps and held valid while not ready (R5)
    for (int n = 0; n < 150; n++) begin
      int a = nextRand() % 200;
      int g = nextRand() % 4;
      for (int k = 0; k < g; k++) cycle(1'b0, 0, 0);
      send(a, a + 1 + nextRand() % 50);
    end
    // Sweep of start times across the horizon values (R2, R3)
    for (int a = 0; a < 64; a++) send(a, a + 3);
    repeat (LAT + 4) cycle(1'b0, 0, 0);
    checks++;
    if (qDue.size() != 0) begin
      fails++;
      $display("FAIL R7 outstanding results: got %0d expected 0", qDue.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1500000;
    checks++; fails++;
    $display("FAIL watchdog expired: got hang expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule